// File: doc/BRIEF.md
# Three-Level PWM Half-Bridge Gate Sequencer

This block is the digital control core of a synchronous buck half-bridge gate driver. It takes a three-level PWM request that an input comparator has already quantized into a two-bit code. From that code it produces the on/off commands for the high-side and low-side switches. Before either switch is turned on, it inserts a dead time that adapts to the gate-state feedback of the opposite switch, followed by a minimum timer. A watchdog lets the sequence continue if that feedback never arrives.

The mid level is the light-load mode. The high-side switch stays off, and a low-side switch that is already conducting is held on until zero inductor current is detected. Detection uses a switch-node zero-crossing comparator bit. That bit is ignored during a blanking window that starts when the low-side gate feedback shows on, and it must then hold for a debounce window. After a detection the low side stays off until the code returns to high or low.

Both commands are gated by an enable input and a supply-good flag. An open-drain "not ready" pull-down output holds the external enable line low while the supply is bad and during an initialization period after the supply becomes good.

Top module: `hb_gate_seq`

## Requirements
- R1: With `pwm_code` = 2'b10 (high) held and the block running, the block settles to `hs_cmd`=1 and `ls_cmd`=0.
- R2: With `pwm_code` = 2'b00 (low) held and the block running, the block settles to `hs_cmd`=0 and `ls_cmd`=1.
- R3: With `pwm_code` = 2'b01 (mid), `hs_cmd` is 0 from the next clock edge. A conducting or pending low side stays on until zero current is detected and is then turned off. Mid entered while both switches are off leaves both off.
- R4: Once zero current has been detected in mid, `ls_cmd` stays 0 for as long as the code stays mid, even if `zc_in` drops. A following low (or high) code re-arms detection and turns the low side back on.
- R5: If `en_in` or `vcc_good` is 0 at a clock edge, both commands are 0 after that edge. The zero-current latch is cleared.
- R6: `en_pull_dn` is 1 after any edge at which `vcc_good` is 0. It stays 1 until `vcc_good` has been sampled 1 on INIT_CYC consecutive edges, and is 0 afterwards. While it is 1, both commands are 0.
- R7: `hs_cmd` and `ls_cmd` are never 1 together. A switch turns on only after the opposite gate feedback has been sampled off, and then DT_MIN_CYC further edges. With feedback lagging the command by two cycles, the both-off gap is DT_MIN_CYC+2 cycles.
- R8: If the opposite gate feedback stays on, the turn-on goes ahead after FB_TO_CYC edges of waiting plus DT_MIN_CYC edges. The both-off gap is FB_TO_CYC+DT_MIN_CYC cycles.
- R9: In mid, `zc_in` counts only after `ls_fb` has been sampled on for BLANK_CYC edges. It must then be sampled 1 on DEB_CYC consecutive edges. A shorter pulse has no effect. With feedback lagging by two cycles, a fresh low-side on-time with `zc_in` held high lasts 3+BLANK_CYC+DEB_CYC cycles.
- R10: The unused code 2'b11 is handled exactly as mid.
- R11: During and right after reset both commands are 0 and `en_pull_dn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_code | input | 2 | Quantized PWM level: 00 low, 01 mid, 10 high, 11 treated as mid |
| en_in | input | 1 | Driver enable level |
| vcc_good | input | 1 | Supply above lockout threshold |
| hs_fb | input | 1 | High-side gate feedback, 1 = gate on |
| ls_fb | input | 1 | Low-side gate feedback, 1 = gate on |
| zc_in | input | 1 | Switch-node zero-crossing comparator, 1 = current reached zero |
| hs_cmd | output | 1 | High-side gate command |
| ls_cmd | output | 1 | Low-side gate command |
| en_pull_dn | output | 1 | Open-drain pull-down request on the enable line |

## Verification
The bench builds the block with INIT_CYC=10, DT_MIN_CYC=4, FB_TO_CYC=8, BLANK_CYC=6 and DEB_CYC=3. It models gate feedback as the commands delayed by two cycles. These short windows make exact dead-time gaps (6 cycles with live feedback, 12 with forced-stuck feedback) and the exact 12-cycle blanked low-side on-time measurable in a few hundred cycles. They also let the bench walk the supply-good initialization, the sub-debounce glitch and the latch-until-rearm sequence in one short run.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10
    } lvl_e;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_HS_WAIT = 3'd1,
        PH_HS      = 3'd2,
        PH_LS_WAIT = 3'd3,
        PH_LS      = 3'd4
    } phase_e;

    // Unused code 2'b11 collapses onto the mid level.
    function automatic lvl_e decode_lvl(input logic [1:0] code);
        case (code)
            2'b00:   return LVL_LOW;
            2'b10:   return LVL_HIGH;
            default: return LVL_MID;
        endcase
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/hbd_supply_seq.sv
module hbd_supply_seq
    import hbd_pkg::*;
#(
    parameter int unsigned INIT_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic vcc_good,
    output logic ready,
    output logic pull_dn
);
    localparam int unsigned CW = cnt_width(INIT_CYC);

    generate
        if (INIT_CYC == 0) begin : g_no_init
            always_ff @(posedge clk) begin
                if (rst) ready <= 1'b0;
                else     ready <= vcc_good;
            end
        end else begin : g_init
            logic [CW-1:0] init_cnt;
            always_ff @(posedge clk) begin
                if (rst || !vcc_good) begin
                    init_cnt <= '0;
                    ready    <= 1'b0;
                end else if (!ready) begin
                    if (init_cnt == CW'(INIT_CYC - 1)) ready <= 1'b1;
                    else                               init_cnt <= init_cnt + 1'b1;
                end
            end
        end
    endgenerate

    assign pull_dn = !ready;

endmodule

// File: rtl/hbd_zcd.sv
module hbd_zcd
    import hbd_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 18,
    parameter int unsigned DEB_CYC   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,      // leave mid or disabled
    input  logic ls_active,  // sequencer holds the low side on
    input  logic ls_fb,
    input  logic mid_sel,
    input  logic zc_in,
    output logic zc_done
);
    localparam int unsigned BW = cnt_width(BLANK_CYC);
    localparam int unsigned DW = cnt_width(DEB_CYC);

    logic [BW-1:0] blank_cnt;
    logic [DW-1:0] deb_cnt;
    logic          blank_done;

    assign blank_done = (blank_cnt == BW'(BLANK_CYC));

    // Blanking window starts once the low-side gate is seen on.
    always_ff @(posedge clk) begin
        if (rst || !(ls_active && ls_fb)) blank_cnt <= '0;
        else if (!blank_done)             blank_cnt <= blank_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            deb_cnt <= '0;
            zc_done <= 1'b0;
        end else if (mid_sel && blank_done && zc_in && !zc_done) begin
            if (deb_cnt == DW'(DEB_CYC - 1)) zc_done <= 1'b1;
            else                             deb_cnt <= deb_cnt + 1'b1;
        end else begin
            deb_cnt <= '0;
        end
    end

endmodule

// File: rtl/hbd_overlap_fsm.sv
module hbd_overlap_fsm
    import hbd_pkg::*;
#(
    parameter int unsigned DT_MIN_CYC = 3,
    parameter int unsigned FB_TO_CYC  = 25
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  lvl_e   lvl,
    input  logic   zc_done,
    input  logic   hs_fb,
    input  logic   ls_fb,
    output phase_e phase,
    output logic   hs_cmd,
    output logic   ls_cmd
);
    localparam int unsigned TW = cnt_width(DT_MIN_CYC);
    localparam int unsigned WW = cnt_width(FB_TO_CYC);

    phase_e        ph_nx;
    logic [TW-1:0] dt_cnt;
    logic [WW-1:0] wd_cnt;
    logic          want_hs, want_ls, in_wait, other_fb, wd_exp, gate_ok, dt_done;

    assign want_hs  = (lvl == LVL_HIGH);
    assign want_ls  = (lvl == LVL_LOW) ||
                      ((lvl == LVL_MID) && !zc_done && (phase != PH_IDLE));
    assign in_wait  = (phase == PH_HS_WAIT) || (phase == PH_LS_WAIT);
    assign other_fb = (phase == PH_HS_WAIT) ? ls_fb : hs_fb;
    assign wd_exp   = (wd_cnt == WW'(FB_TO_CYC));
    assign gate_ok  = !other_fb || wd_exp;
    assign dt_done  = gate_ok && (dt_cnt == TW'(DT_MIN_CYC - 1));

    always_comb begin
        ph_nx = phase;
        case (phase)
            PH_IDLE: begin
                if (want_hs)      ph_nx = PH_HS_WAIT;
                else if (want_ls) ph_nx = PH_LS_WAIT;
            end
            PH_HS_WAIT: begin
                if (!want_hs)     ph_nx = want_ls ? PH_LS_WAIT : PH_IDLE;
                else if (dt_done) ph_nx = PH_HS;
            end
            PH_HS: begin
                if (!want_hs)     ph_nx = want_ls ? PH_LS_WAIT : PH_IDLE;
            end
            PH_LS_WAIT: begin
                if (want_hs)      ph_nx = PH_HS_WAIT;
                else if (!want_ls) ph_nx = PH_IDLE;
                else if (dt_done) ph_nx = PH_LS;
            end
            PH_LS: begin
                if (want_hs)      ph_nx = PH_HS_WAIT;
                else if (!want_ls) ph_nx = PH_IDLE;
            end
            default:              ph_nx = PH_IDLE;
        endcase
        if (!run) ph_nx = PH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= ph_nx;
    end

    // Wait-state timers restart on every phase change.
    always_ff @(posedge clk) begin
        if (rst || (ph_nx != phase) || !in_wait) begin
            dt_cnt <= '0;
            wd_cnt <= '0;
        end else begin
            if (other_fb && !wd_exp)   wd_cnt <= wd_cnt + 1'b1;
            if (gate_ok && !dt_done)   dt_cnt <= dt_cnt + 1'b1;
        end
    end

    assign hs_cmd = (phase == PH_HS);
    assign ls_cmd = (phase == PH_LS);

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
    import hbd_pkg::*;
#(
    parameter int unsigned INIT_CYC   = 1000,
    parameter int unsigned DT_MIN_CYC = 3,
    parameter int unsigned FB_TO_CYC  = 25,
    parameter int unsigned BLANK_CYC  = 18,
    parameter int unsigned DEB_CYC    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pwm_code,
    input  logic       en_in,
    input  logic       vcc_good,
    input  logic       hs_fb,
    input  logic       ls_fb,
    input  logic       zc_in,
    output logic       hs_cmd,
    output logic       ls_cmd,
    output logic       en_pull_dn
);
    lvl_e   lvl;
    phase_e phase;
    logic   ready, run, zc_done, zc_clear;

    assign lvl      = decode_lvl(pwm_code);
    assign run      = ready && en_in && vcc_good;
    assign zc_clear = !run || (lvl != LVL_MID);

    hbd_supply_seq #(.INIT_CYC(INIT_CYC)) u_supply (
        .clk      (clk),
        .rst      (rst),
        .vcc_good (vcc_good),
        .ready    (ready),
        .pull_dn  (en_pull_dn)
    );

    hbd_zcd #(.BLANK_CYC(BLANK_CYC), .DEB_CYC(DEB_CYC)) u_zcd (
        .clk       (clk),
        .rst       (rst),
        .clear     (zc_clear),
        .ls_active (phase == PH_LS),
        .ls_fb     (ls_fb),
        .mid_sel   (lvl == LVL_MID),
        .zc_in     (zc_in),
        .zc_done   (zc_done)
    );

    hbd_overlap_fsm #(.DT_MIN_CYC(DT_MIN_CYC), .FB_TO_CYC(FB_TO_CYC)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .lvl     (lvl),
        .zc_done (zc_done),
        .hs_fb   (hs_fb),
        .ls_fb   (ls_fb),
        .phase   (phase),
        .hs_cmd  (hs_cmd),
        .ls_cmd  (ls_cmd)
    );

endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk #(
    parameter int unsigned DT_MIN_CYC = 3
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] pwm_code,
    input logic       en_in,
    input logic       vcc_good,
    input logic       hs_cmd,
    input logic       ls_cmd,
    input logic       en_pull_dn
);
    logic [7:0] off_cnt;

    always_ff @(posedge clk) begin
        if (rst || hs_cmd || ls_cmd) off_cnt <= '0;
        else if (off_cnt != 8'hFF)   off_cnt <= off_cnt + 1'b1;
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(hs_cmd && ls_cmd)); // R7

    AST_HS_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_cmd) |-> (off_cnt >= DT_MIN_CYC)); // R7

    AST_HS_FROM_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_cmd) |-> ($past(pwm_code) == 2'b10)); // R1

    AST_MID_HS_OFF: assert property (@(posedge clk) disable iff (rst)
        (pwm_code[0] == 1'b1) |=> !hs_cmd); // R3

    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en_in || !vcc_good) |=> (!hs_cmd && !ls_cmd)); // R5

    AST_SUPPLY_PD: assert property (@(posedge clk) disable iff (rst)
        !vcc_good |=> en_pull_dn); // R6

    AST_PD_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        en_pull_dn |-> (!hs_cmd && !ls_cmd)); // R6

endmodule

bind hb_gate_seq hb_gate_seq_chk #(.DT_MIN_CYC(DT_MIN_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwm_code   (pwm_code),
    .en_in      (en_in),
    .vcc_good   (vcc_good),
    .hs_cmd     (hs_cmd),
    .ls_cmd     (ls_cmd),
    .en_pull_dn (en_pull_dn)
);

// File: tb/hb_gate_seq_tb_top.sv
`timescale 1ns/1ps
module hb_gate_seq_tb_top;

    localparam int INIT_CYC = 10;
    localparam int DT_MIN   = 4;
    localparam int FB_TO    = 8;
    localparam int BLANK    = 6;
    localparam int DEB      = 3;
    localparam int FBD      = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pwm_code = 2'b00;
    logic       en_in = 1'b0;
    logic       vcc_good = 1'b0;
    logic       zc_in = 1'b0;
    logic       force_ls_fb = 1'b0;
    logic       hs_fb, ls_fb, hs_cmd, ls_cmd, en_pull_dn;
    logic [FBD-1:0] hs_pipe, ls_pipe;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    hb_gate_seq #(
        .INIT_CYC(INIT_CYC), .DT_MIN_CYC(DT_MIN), .FB_TO_CYC(FB_TO),
        .BLANK_CYC(BLANK), .DEB_CYC(DEB)
    ) dut_i (
        .clk(clk), .rst(rst), .pwm_code(pwm_code), .en_in(en_in),
        .vcc_good(vcc_good), .hs_fb(hs_fb), .ls_fb(ls_fb), .zc_in(zc_in),
        .hs_cmd(hs_cmd), .ls_cmd(ls_cmd), .en_pull_dn(en_pull_dn)
    );

    // Gate feedback model: commands seen FBD cycles later.
    always_ff @(posedge clk) begin
        if (rst) begin
            hs_pipe <= '0;
            ls_pipe <= '0;
        end else begin
            hs_pipe <= {hs_pipe[FBD-2:0], hs_cmd};
            ls_pipe <= {ls_pipe[FBD-2:0], ls_cmd};
        end
    end
    assign hs_fb = hs_pipe[FBD-1];
    assign ls_fb = ls_pipe[FBD-1] | force_ls_fb;

    // Scoreboard
    typedef struct {
        logic  hs;
        logic  ls;
        logic  pd;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_tests++;
            if (hs_cmd !== e.hs || ls_cmd !== e.ls || en_pull_dn !== e.pd) begin
                n_fail++;
                $display("FAIL %s: got hs=%b ls=%b pd=%b, expected hs=%b ls=%b pd=%b",
                         e.tag, hs_cmd, ls_cmd, en_pull_dn, e.hs, e.ls, e.pd);
            end
        end
    end

    // Gap and on-time monitor
    int off_run = 0, last_hs_gap = -1, last_ls_gap = -1;
    int ls_run = 0, last_ls_on = -1;
    logic prev_hs = 1'b0, prev_ls = 1'b0;

    always @(negedge clk) begin
        if (hs_cmd && !prev_hs) last_hs_gap = off_run;
        if (ls_cmd && !prev_ls) last_ls_gap = off_run;
        if (!ls_cmd && prev_ls) last_ls_on = ls_run;
        if (hs_cmd || ls_cmd) off_run = 0; else off_run++;
        if (ls_cmd) ls_run++; else ls_run = 0;
        prev_hs = hs_cmd;
        prev_ls = ls_cmd;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic hs, input logic ls, input logic pd, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        e.hs = hs; e.ls = ls; e.pd = pd; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic chk_val(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        cycles(3);
        expect_out(0, 0, 1, "R11 reset state");
        @(negedge clk) rst = 1'b0;
        en_in = 1'b1;
        cycles(5);
        expect_out(0, 0, 1, "R6 supply bad holds pull-down");

        pwm_code = 2'b00;
        vcc_good = 1'b1;
        cycles(3);
        expect_out(0, 0, 1, "R6 init period keeps pull-down and outputs off");
        cycles(INIT_CYC);
        expect_out(0, 1, 0, "R6 released after init");
        cycles(12);
        expect_out(0, 1, 0, "R2 low level");

        pwm_code = 2'b10;
        cycles(15);
        expect_out(1, 0, 0, "R1 high level");
        chk_val("R7 gap before high-side on", last_hs_gap, FBD + DT_MIN);

        pwm_code = 2'b00;
        cycles(15);
        expect_out(0, 1, 0, "R2 back to low");
        chk_val("R7 gap before low-side on", last_ls_gap, FBD + DT_MIN);

        pwm_code = 2'b01;
        cycles(30);
        expect_out(0, 1, 0, "R3 mid holds low side");

        zc_in = 1'b1;
        cycles(DEB - 1);
        zc_in = 1'b0;
        cycles(5);
        expect_out(0, 1, 0, "R9 short zero-cross pulse ignored");

        zc_in = 1'b1;
        cycles(10);
        expect_out(0, 0, 0, "R3 zero current ends low side");
        zc_in = 1'b0;
        cycles(10);
        expect_out(0, 0, 0, "R4 latched off in mid");

        pwm_code = 2'b10;
        cycles(15);
        expect_out(1, 0, 0, "R1 high after mid");
        pwm_code = 2'b01;
        zc_in = 1'b1;
        cycles(30);
        expect_out(0, 0, 0, "R3 mid with zero current");
        chk_val("R9 blanked low-side on-time", last_ls_on, FBD + 1 + BLANK + DEB);

        zc_in = 1'b0;
        pwm_code = 2'b00;
        cycles(15);
        expect_out(0, 1, 0, "R4 low re-arms low side");

        pwm_code = 2'b10;
        cycles(15);
        pwm_code = 2'b11;
        cycles(15);
        expect_out(0, 1, 0, "R10 code 11 acts as mid");

        en_in = 1'b0;
        cycles(2);
        expect_out(0, 0, 0, "R5 enable low turns off");
        pwm_code = 2'b10;
        cycles(3);
        expect_out(0, 0, 0, "R5 enable low ignores high");
        en_in = 1'b1;
        cycles(15);
        expect_out(1, 0, 0, "R5 resume after enable");

        pwm_code = 2'b00;
        cycles(15);
        force_ls_fb = 1'b1;
        pwm_code = 2'b10;
        cycles(25);
        expect_out(1, 0, 0, "R8 stuck feedback proceeds");
        chk_val("R8 watchdog gap", last_hs_gap, FB_TO + DT_MIN);
        force_ls_fb = 1'b0;

        vcc_good = 1'b0;
        cycles(2);
        expect_out(0, 0, 1, "R5 supply loss turns off");
        vcc_good = 1'b1;
        cycles(INIT_CYC + 15);
        expect_out(1, 0, 0, "R6 resume after supply recovers");

        cycles(3);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule